// File: doc/BRIEF.md
# Counterflow Convolution Array with Resident Coefficients

This block computes a running FIR convolution over a sample stream on a linear chain of multiply-accumulate cells. Each cell keeps one coefficient that stays put once loaded. Samples enter at cell 0 and step one cell toward the far end on every clock. Partial sums start as zero at the far end and step one cell back toward cell 0 on every clock. When a sample and a partial sum pass through the same cell, the cell adds its coefficient times the sample into the sum. A sum that reaches cell 0 is complete and leaves through the result port. No separate collection bus is needed.

Because the two streams move against each other, a sample must be followed by an empty cycle so that it meets every partial sum. The block therefore opens a sample slot on every second cycle. The first cycle after reset is a slot. A result appears one cycle after its sample is accepted, so the response time is constant, and at most one result comes out every two cycles. Coefficients are loaded through a shift chain while streaming is paused. The intended use is to load the taps, stream samples into the slots, and read one filtered value per accepted sample.

Top module: `counterflow_fir`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_vld` is 0. Reset clears all coefficients to zero and empties the array, so a sample accepted after reset and before any load produces a result of 0.
- R2: Cycles after reset are numbered from 0, starting with the first cycle in which reset is low. A sample is accepted only in an even-numbered cycle. A sample offered in an odd cycle produces no result and does not change any later result.
- R3: In each cycle with `ld_en` high, `ld_coef` shifts into cell 0 and every stored coefficient moves one cell toward cell TAPS-1. After TAPS loads, the first word loaded sits in cell TAPS-1 and the last in cell 0. With `ld_en` low, the coefficients do not change.
- R4: A sample offered in a cycle with `ld_en` high is not accepted. It produces no result, and its slot counts as a zero sample.
- R5: `res_vld` is high for exactly one cycle: the cycle after each accepted sample. It is low in every other cycle.
- R6: The result for an accepted sample equals sum over m = 0..TAPS-1 of h[m]·s[n-m]. Here h[m] is the coefficient in cell m, s[n] is the sample just accepted, and s[n-m] is the sample accepted m slots earlier, or zero if that slot took no sample. Samples and coefficients are 8-bit two's complement, and the result is 20-bit two's complement.
- R7: When a sample is accepted in every slot, the results come out on every second cycle, one per sample, and each is correct.
- R8: Results are exact at the extremes of the signed range, including TAPS products of -128·-128, which sum to 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Shift `ld_coef` into the coefficient chain this cycle |
| ld_coef | input | 8 | Coefficient word, two's complement |
| smp_vld | input | 1 | A sample is offered this cycle |
| smp_data | input | 8 | Sample value, two's complement |
| res_vld | output | 1 | A finished result is on `res_data` |
| res_data | output | 20 | Convolution result, two's complement |

## Verification
The hardest case to reach is a partial sum that meets a mix of real samples, empty slots, samples that were refused because they fell in an odd cycle, and samples that were refused during a load. Reaching it needs stimulus that does not line up with the slot rhythm. The table walk offers a sample in both even and odd cycles and leaves some slots empty. It also toggles `ld_coef` while `ld_en` is low, so each output depends on which offers the block actually took and on which coefficients stayed in place. Directed sequences then cover the order of the load chain using an impulse, full-scale negative products, and a reset in the middle of a stream.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
    parameter int TAPS   = 4;
    parameter int SMP_W  = 8;
    parameter int COEF_W = 8;
    parameter int ACC_W  = 20;

    localparam int PROD_W = SMP_W + COEF_W;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [TAPS-1:0][COEF_W-1:0] coef_vec_t;

    typedef struct packed {
        logic vld;
        smp_t val;
    } slot_t;

    // Add w*x into the passing sum when the sample slot is occupied.
    function automatic acc_t cell_mac(acc_t y, slot_t x, coef_t w);
        acc_t p;
        p = acc_t'(x.val) * acc_t'(w);
        return x.vld ? acc_t'(y + p) : y;
    endfunction
endpackage

// File: rtl/cfa_phase.sv
module cfa_phase (
    input  logic clk,
    input  logic rst,
    output logic slot_q
);
    // High on cycles 0, 2, 4, ... after reset: these are the sample slots.
    always_ff @(posedge clk) begin
        if (rst) slot_q <= 1'b1;
        else     slot_q <= ~slot_q;
    end
endmodule

// File: rtl/cfa_coef_chain.sv
module cfa_coef_chain
    import cfa_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_en,
    input  logic [COEF_W-1:0]   ld_coef,
    output coef_vec_t           coef_q
);
    // Word enters cell 0 and ripples toward cell TAPS-1.
    always_ff @(posedge clk) begin
        if (rst)        coef_q <= '0;
        else if (ld_en) coef_q <= {coef_q[TAPS-2:0], ld_coef};
    end
endmodule

// File: rtl/cfa_cell.sv
module cfa_cell
    import cfa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  coef_t coef,
    input  slot_t x_in,
    input  acc_t  y_in,
    output slot_t x_q,
    output acc_t  y_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q <= x_in;
            y_q <= cell_mac(y_in, x_in, coef);
        end
    end
endmodule

// File: rtl/counterflow_fir.sv
module counterflow_fir
    import cfa_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_en,
    input  logic [cfa_pkg::COEF_W-1:0] ld_coef,
    input  logic                      smp_vld,
    input  logic [cfa_pkg::SMP_W-1:0]  smp_data,
    output logic                      res_vld,
    output logic [cfa_pkg::ACC_W-1:0]  res_data
);
    logic      slot_q;
    coef_vec_t coef_q;
    slot_t     x_in [TAPS];
    slot_t     x_q  [TAPS];
    acc_t      y_in [TAPS];
    acc_t      y_q  [TAPS];

    cfa_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .slot_q (slot_q)
    );

    cfa_coef_chain u_coef (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_coef (ld_coef),
        .coef_q  (coef_q)
    );

    for (genvar c = 0; c < TAPS; c++) begin : g_cell
        // Samples flow from cell 0 upward.
        if (c == 0) begin : g_xhead
            always_comb begin
                x_in[c].vld = smp_vld & slot_q & ~ld_en;
                x_in[c].val = smp_t'(smp_data);
            end
        end else begin : g_xlink
            assign x_in[c] = x_q[c-1];
        end
        // Partial sums flow from cell TAPS-1 downward, seeded with zero.
        if (c == TAPS-1) begin : g_yseed
            assign y_in[c] = '0;
        end else begin : g_ylink
            assign y_in[c] = y_q[c+1];
        end

        cfa_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .coef (coef_t'(coef_q[c])),
            .x_in (x_in[c]),
            .y_in (y_in[c]),
            .x_q  (x_q[c]),
            .y_q  (y_q[c])
        );
    end

    assign res_vld  = x_q[0].vld;
    assign res_data = y_q[0];
endmodule

// File: rtl/counterflow_fir_chk.sv
module counterflow_fir_chk
    import cfa_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      ld_en,
    input logic      smp_vld,
    input logic      res_vld,
    input coef_vec_t coefs
);
    logic slot_c;
    logic take;

    always_ff @(posedge clk) begin
        if (rst) slot_c <= 1'b1;
        else     slot_c <= ~slot_c;
    end

    assign take = smp_vld & ~ld_en & slot_c;

    p_result_follows_r5: assert property (@(posedge clk) disable iff (rst)
        take |=> res_vld);

    p_result_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> $past(take));

    p_spaced_results_r7: assert property (@(posedge clk) disable iff (rst)
        res_vld |=> !res_vld);

    p_odd_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        !slot_c |=> !res_vld);

    p_load_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> !res_vld);

    p_coef_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(coefs));
endmodule

bind counterflow_fir counterflow_fir_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .smp_vld (smp_vld),
    .res_vld (res_vld),
    .coefs   (coef_q)
);

// File: tb/counterflow_fir_bench.sv
module counterflow_fir_bench;
    import cfa_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              ld_en;
    logic [COEF_W-1:0] ld_coef;
    logic              smp_vld;
    logic [SMP_W-1:0]  smp_data;
    logic              res_vld;
    logic [ACC_W-1:0]  res_data;

    always #4 clk = ~clk;

    counterflow_fir u_counterflow_fir (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .ld_coef  (ld_coef),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .res_vld  (res_vld),
        .res_data (res_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc_n = 0;
    int hw   [TAPS];
    int hist [TAPS];

    // {offer, value}; offers land in both even and odd cycles.
    localparam int NVEC = 20;
    localparam logic [8:0] VEC [NVEC] = '{
        9'h1_05, 9'h1_7F, 9'h1_FE, 9'h0_33, 9'h1_80, 9'h1_11,
        9'h0_00, 9'h0_44, 9'h1_09, 9'h1_F0, 9'h1_7F, 9'h0_00,
        9'h1_C3, 9'h1_25, 9'h0_00, 9'h0_00, 9'h1_01, 9'h1_FF,
        9'h1_60, 9'h0_00
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic ld, input int ldw, input logic sv,
                       input int sd, input string tag);
        bit    take;
        bit    even;
        int    exp;
        string vtag;
        even = (cyc_n % 2 == 0);
        take = sv && !ld && even;
        ld_en    = ld;
        ld_coef  = ldw[COEF_W-1:0];
        smp_vld  = sv;
        smp_data = sd[SMP_W-1:0];
        if (even) begin
            for (int m = TAPS-1; m > 0; m--) hist[m] = hist[m-1];
            hist[0] = take ? int'($signed(sd[SMP_W-1:0])) : 0;
        end
        if (ld) begin
            for (int m = TAPS-1; m > 0; m--) hw[m] = hw[m-1];
            hw[0] = int'($signed(ldw[COEF_W-1:0]));
        end
        exp = 0;
        for (int m = 0; m < TAPS; m++) exp += hw[m] * hist[m];
        if (sv && ld)         vtag = "R4 valid";
        else if (sv && !even) vtag = "R2 valid";
        else                  vtag = "R5 valid";
        @(posedge clk);
        #1;
        check(vtag, int'(res_vld), int'(take));
        if (take && res_vld) check(tag, int'($signed(res_data)), exp);
        cyc_n++;
    endtask

    task automatic do_reset();
        rst = 1'b1; ld_en = 1'b0; ld_coef = '0; smp_vld = 1'b0; smp_data = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", int'(res_vld), 0);
        rst = 1'b0;
        cyc_n = 0;
        for (int m = 0; m < TAPS; m++) begin hw[m] = 0; hist[m] = 0; end
    endtask

    task automatic flush();
        for (int i = 0; i < 2*TAPS; i++) cyc(1'b0, 0, 1'b0, 0, "R5 flush");
    endtask

    // Offers a sample on every load cycle: must be refused.
    task automatic load4(input int h0, input int h1, input int h2, input int h3);
        cyc(1'b1, h3, 1'b1, 55, "R4 load");
        cyc(1'b1, h2, 1'b1, 66, "R4 load");
        cyc(1'b1, h1, 1'b1, 77, "R4 load");
        cyc(1'b1, h0, 1'b1, 88, "R4 load");
    endtask

    task automatic slot(input int v, input string tag);
        cyc(1'b0, 0, 1'b1, v, tag);
        cyc(1'b0, 0, 1'b0, 0, tag);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL R5 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: first cycle after reset, array empty, zero coefficients.
        check("R1 valid after reset", int'(res_vld), 0);
        slot(9, "R1 zero coef");
        flush();

        // R3: load order checked with an impulse.
        load4(3, -2, 5, 1);
        slot(1, "R3 impulse h0");
        slot(0, "R3 impulse h1");
        slot(0, "R3 impulse h2");
        slot(0, "R3 impulse h3");
        slot(0, "R3 impulse tail");

        // R6/R2/R3: table walk, both parities, ld_coef noise with ld_en low.
        for (int i = 0; i < NVEC; i++)
            cyc(1'b0, int'(VEC[i][7:0]), VEC[i][8], int'($signed(VEC[i][7:0])), "R6 table");

        // R7: a sample in every slot.
        flush();
        for (int i = 0; i < 6; i++) slot(i * 21 - 50, "R7 back to back");

        // R4: refused offers during a load count as zero slots.
        flush();
        load4(1, 1, 1, 1);
        slot(10, "R4 after load");
        slot(20, "R4 after load");

        // R8: full-scale negative products.
        flush();
        load4(-128, -128, -128, -128);
        for (int i = 0; i < 5; i++) slot(-128, "R8 extreme");
        slot(127, "R8 mixed");
        slot(-128, "R8 mixed");

        // R1: reset in the middle of a stream clears the coefficients.
        do_reset();
        slot(100, "R1 after midstream reset");
        slot(-7, "R1 after midstream reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule